// File: doc/BRIEF.md
# One-Shot Interval Timer

A 16-bit down-counter that a host programs one byte at a time. A write to the low byte address only stages that byte. A write to the high byte address completes the 16-bit value, copies it into the counter and arms the timer. The counter moves down by one on every cycle in which `tick_i` is high. When the count underflows from 0x0000 to 0xFFFF while the timer is armed, the block sends a one-cycle set pulse to an external interrupt controller and disarms. The counter then keeps running and wraps without firing again until the next high-byte write.

The host can read either byte of the live count. A low-byte read and a high-byte write each send a one-cycle clear pulse to the interrupt controller. The byte width and the counter width are parameters. The low byte is always at address 0, and the byte that loads the counter is always at the highest address.

Top module: `oneshot_timer`

## Requirements
- R1: Reset sets the staging latch to 0xFFFF, the count to 0xFFFF, `rdata_o` to 0 and the timer to disarmed. Until the first high-byte write, no set pulse appears, including when the counter wraps.
- R2: A write to address 0 stores `wdata_i` in the low half of the staging latch. The count is not changed.
- R3: A write to address 1 loads the counter with {`wdata_i`, staged low byte} at that clock edge and arms the timer. `flag_clr_o` is high for exactly the following cycle.
- R4: In a cycle with `tick_i` high and no load, the count decreases by 1 modulo 2^16. Without `tick_i` the count holds.
- R5: A high-byte write in the same cycle as `tick_i` loads the written value, and that tick is lost.
- R6: A tick at count 0x0000 while the timer is armed makes the count 0xFFFF and drives `flag_set_o` high for exactly the next cycle. A value N that is loaded therefore fires after N+1 ticks.
- R7: After firing, the timer is disarmed. Later underflows raise no set pulse until the next high-byte write.
- R8: A read presents on `rdata_o`, in the next cycle, the count byte the address selects (0 = bits 7:0, 1 = bits 15:8) as it stood before that edge. `rdata_o` holds between reads. A read of address 0 pulses `flag_clr_o`; a read of address 1 does not.
- R9: A read of address 0 in the same cycle as an expiring tick still returns the data, but no clear pulse is sent, so the set pulse stands alone.
- R10: The staging latch keeps its low byte across loads, so a high-byte write on its own reuses the last staged low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 1 | Byte address: 0 = low, 1 = high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| flag_set_o | output | 1 | One-cycle expiry pulse to the interrupt controller |
| flag_clr_o | output | 1 | One-cycle flag-clear pulse to the interrupt controller |

## Verification
The hardest states to reach are the silent wraparounds. Both the idle wrap after reset and the wrap after a completed one-shot require the counter to travel the full 65536 ticks. Directed runs therefore tick continuously through a complete wrap in each of these states, and a reference model checks that no set pulse appears.

The collision between a low-byte read and the expiring tick requires the read to land on the exact cycle the count is zero. A directed sequence loads a small value, counts the ticks precisely and then issues the read.

Seeded random traffic uses mostly small high bytes so that many expiries occur, and it mixes in staging writes, loads that coincide with ticks, and reads of both addresses.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  parameter int unsigned OST_CNT_W  = 16;
  parameter int unsigned OST_BYTE_W = 8;
endpackage

// File: rtl/oneshot_stage.sv
module oneshot_stage #(
  parameter int unsigned CNT_W  = oneshot_pkg::OST_CNT_W,
  parameter int unsigned BYTE_W = oneshot_pkg::OST_BYTE_W,
  localparam int unsigned NBYTES = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  localparam int unsigned LAST = NBYTES - 1;

  logic [CNT_W-1:0] stage_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[b*BYTE_W +: BYTE_W] <= '1;
      else if (wr_en_i && addr_i == ADDR_W'(b)) stage_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  assign load_o     = wr_en_i && (addr_i == ADDR_W'(LAST));
  assign load_val_o = {wdata_i, stage_q[CNT_W-BYTE_W-1:0]};

  assert_stage_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> stage_q[BYTE_W-1:0] == $past(wdata_i));
  assert_stage_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == '0) |=> $stable(stage_q[BYTE_W-1:0]));
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count #(
  parameter int unsigned CNT_W = oneshot_pkg::OST_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             flag_set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             set_q;

  // load wins over a coincident tick
  assign expire_o = !load_i && tick_i && armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      armed_q <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      set_q <= expire_o;
      if (load_i) begin
        cnt_q   <= load_val_i;
        armed_q <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (expire_o) armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign flag_set_o = set_q;

  assert_load_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)) && armed_q);
  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  assert_fire_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q |-> (cnt_q == '1) && !armed_q);
  assert_stay_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !load_i) |=> !armed_q && !set_q);
endmodule

// File: rtl/oneshot_rdport.sv
module oneshot_rdport #(
  parameter int unsigned CNT_W  = oneshot_pkg::OST_CNT_W,
  parameter int unsigned BYTE_W = oneshot_pkg::OST_BYTE_W,
  localparam int unsigned NBYTES = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              expire_i,
  input  logic              flag_set_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_clr_o
);
  logic [BYTE_W-1:0] rdata_q;
  logic              clr_q;
  logic              rd_low;

  assign rd_low = rd_en_i && (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      clr_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= cnt_i[int'(addr_i)*BYTE_W +: BYTE_W];
      // a coincident expiry keeps the flag up
      clr_q <= load_i || (rd_low && !expire_i);
    end
  end

  assign rdata_o    = rdata_q;
  assign flag_clr_o = clr_q;

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  assert_no_set_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_set_i && flag_clr_o));
  assert_clr_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flag_clr_o);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned CNT_W  = oneshot_pkg::OST_CNT_W,
  parameter int unsigned BYTE_W = oneshot_pkg::OST_BYTE_W,
  localparam int unsigned NBYTES = CNT_W / BYTE_W,
  localparam int unsigned ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_set_o,
  output logic              flag_clr_o
);
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  oneshot_stage #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_stage (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .load_o(load), .load_val_o(load_val)
  );

  oneshot_count #(.CNT_W(CNT_W)) u_count (
    .clk_i, .rst_ni, .tick_i,
    .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .expire_o(expire), .flag_set_o
  );

  oneshot_rdport #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rdport (
    .clk_i, .rst_ni, .rd_en_i, .addr_i,
    .load_i(load), .expire_i(expire), .flag_set_i(flag_set_o),
    .cnt_i(cnt), .rdata_o, .flag_clr_o
  );

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_set_o) |-> $past(tick_i));
endmodule

// File: tb/tb_oneshot_timer.sv
`timescale 1ns/1ps
module tb_oneshot_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [0:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fset, fclr;

  int checks = 0, fails = 0, fires = 0;
  logic [15:0] m_latch = 16'hFFFF, m_cnt = 16'hFFFF;
  logic        m_armed = 1'b0;
  logic [7:0]  m_rdata = '0;
  logic        m_set = 1'b0, m_clr = 1'b0;
  bit          done = 0;

  always #4 clk = ~clk;

  oneshot_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .flag_set_o(fset), .flag_clr_o(fclr)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic fire_now(logic t, logic w, logic a);
    return !(w && a) && t && m_armed && (m_cnt == 16'h0000);
  endfunction

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(string tag, logic t, logic w, logic r, logic a, logic [7:0] d);
    logic f;
    tick = t; wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    f = fire_now(t, w, a);
    if (r) m_rdata = a ? m_cnt[15:8] : m_cnt[7:0];
    m_set = f;
    m_clr = (w && a) || (r && !a && !f);
    if (w && a) begin
      m_cnt = {d, m_latch[7:0]};
      m_latch[15:8] = d;
      m_armed = 1'b1;
    end else begin
      if (w && !a) m_latch[7:0] = d;
      if (t) begin
        m_cnt = m_cnt - 16'd1;
        if (f) m_armed = 1'b0;
      end
    end
    @(negedge clk);
    tick = 0; wr = 0; rd = 0;
    if (fset) fires++;
    chk({tag, " flag_set"}, {15'd0, fset}, {15'd0, m_set});
    chk({tag, " flag_clr"}, {15'd0, fclr}, {15'd0, m_clr});
    if (r) chk({tag, " rdata"}, {8'd0, rdata}, {8'd0, m_rdata});
  endtask

  task automatic read16(string tag, logic [15:0] exp);
    logic [7:0] lo;
    step(tag, 0, 0, 1, 0, 8'h00); lo = rdata;
    step(tag, 0, 0, 1, 1, 8'h00);
    chk({tag, " count"}, {rdata, lo}, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", {8'd0, rdata}, 16'h0000);
    chk("R1 flag_set", {15'd0, fset}, 16'd0);
    chk("R1 flag_clr", {15'd0, fclr}, 16'd0);
    read16("R1", 16'hFFFF);
    // R1 idle wrap without a flag
    f0 = fires;
    for (int i = 0; i < 65540; i++) step("R1", 1, 0, 0, 0, 8'h00);
    chk("R1 idle fires", 16'(fires - f0), 16'd0);
    // R2 staging leaves count alone
    step("R2", 0, 1, 0, 0, 8'h05);
    read16("R2", 16'hFFFB);
    // R3 load arms and clears
    step("R3", 0, 1, 0, 1, 8'h00);
    chk("R3 clr pulse", {15'd0, fclr}, 16'd1);
    read16("R3", 16'h0005);
    // R4 hold then decrement
    repeat (3) step("R4", 0, 0, 0, 0, 8'h00);
    step("R4", 1, 0, 0, 0, 8'h00);
    step("R4", 1, 0, 0, 0, 8'h00);
    read16("R4", 16'h0003);
    // R6 fires after the remaining ticks
    f0 = fires;
    for (int i = 0; i < 4; i++) step("R6", 1, 0, 0, 0, 8'h00);
    chk("R6 fires", 16'(fires - f0), 16'd1);
    read16("R6", 16'hFFFF);
    // R7 silent wrap after expiry
    f0 = fires;
    for (int i = 0; i < 65540; i++) step("R7", 1, 0, 0, 0, 8'h00);
    chk("R7 fires", 16'(fires - f0), 16'd0);
    // R5 load with coincident tick
    step("R5", 0, 1, 0, 0, 8'h02);
    step("R5", 1, 1, 0, 1, 8'h00);
    read16("R5", 16'h0002);
    // R9 low read on expiry cycle
    step("R9", 1, 0, 0, 0, 8'h00);
    step("R9", 1, 0, 0, 0, 8'h00);
    step("R9", 1, 0, 1, 0, 8'h00);
    chk("R9 set", {15'd0, fset}, 16'd1);
    chk("R9 clr", {15'd0, fclr}, 16'd0);
    chk("R9 rdata", {8'd0, rdata}, 16'h0000);
    // R8 high read has no clear
    step("R8", 0, 0, 1, 1, 8'h00);
    chk("R8 hi no clr", {15'd0, fclr}, 16'd0);
    // R10 reuse staged low byte
    step("R10", 0, 1, 0, 1, 8'h01);
    read16("R10", 16'h0102);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic a;
      a = 1'($urandom);
      d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
      if (a && ($urandom % 3 != 0)) d = 8'h00;
      step("R8 random", 1'($urandom), ($urandom % 10) == 0, ($urandom % 4) == 0, a, d);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule